// File: doc/BRIEF.md
# Streaming Hamming Page Code Generator

This block computes a three-byte single-error-correcting parity code over a 256-byte data block delivered one byte per accepted cycle. A producer asserts `start_i` at the start of a block and then streams the bytes with `valid_i`. There is no backpressure, so every byte presented with `valid_i` high is consumed.

Each byte yields six column parities and one overall parity. The column parities are folded into a running register. For bytes with odd overall parity, the byte's index in the block is folded into a true line register, and its bitwise complement into a complement line register. After the last byte the registers are packed into the code, and `done_o` pulses for one cycle. The accumulators then restart at index zero, so blocks may follow each other back to back without a new start.

A block made of erased bytes (all bits set) produces a code with every bit set. An erased page therefore needs no special case when the code is checked later.

Top module: `hamming_ecc_stream`

## Requirements
- R1: While `rst_ni` is low, `done_o` is 0 and `ecc_o` is 24'h000000.
- R2: A byte is consumed only in a cycle with `valid_i` high. Cycles without `valid_i` change no state. A block is complete after exactly 256 consumed bytes, with indices 0 to 255 in arrival order.
- R3: When a consumed byte has an odd number of set bits, its index is XORed into a true line register T and its 8-bit complement into a complement line register C. `ecc_o[23:16]` is the inverse of {T7,C7,T6,C6,T5,C5,T4,C4}, and `ecc_o[15:8]` is the inverse of {T3,C3,T2,C2,T1,C1,T0,C0}.
- R4: Per byte, with d the data bits, the column parities are:
  - P0 = d0^d2^d4^d6 and P1 = d1^d3^d5^d7
  - P2 = d0^d1^d4^d5 and P3 = d2^d3^d6^d7
  - P4 = d0^d1^d2^d3 and P5 = d4^d5^d6^d7

  Each is XOR-accumulated over the block. `ecc_o[7:2]` holds the inverted accumulated P5..P0, with P5 in bit 7, and `ecc_o[1:0]` is 2'b11.
- R5: `done_o` is high for exactly the one cycle after the clock edge that consumes byte 255. `ecc_o` carries the new code in that same cycle.
- R6: `ecc_o` changes only when `done_o` rises and holds its value in every other cycle.
- R7: `start_i` discards any partial block. A byte presented with `valid_i` in the same cycle as `start_i` is byte 0 of the new block. A start that coincides with what would have been byte 255 produces no `done_o`.
- R8: After a block completes, the next consumed byte is byte 0 of a new block, with no `start_i` needed.
- R9: A block of 256 bytes of 8'hFF produces `ecc_o` = 24'hFFFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new block and discard partial state |
| valid_i | input | 1 | `data_i` carries a byte this cycle |
| data_i | input | 8 | Data byte |
| done_o | output | 1 | One-cycle pulse when a code is ready |
| ecc_o | output | 24 | Code: byte 0 in [23:16], byte 1 in [15:8], byte 2 in [7:0] |

## Verification
Two functions can meet in one cycle: a start and a consumed byte. The worst case is a start that lands on the cycle in which byte 255 would complete a block. The bench provokes this in three ways: a start with data at the head of a block, a start in the middle of a block, and a start exactly on the would-be last byte. A behavioural model, which folds parities bit by bit and tracks the index as an integer, then judges `done_o` and `ecc_o` on every cycle. The bench also mixes idle gaps and back-to-back blocks, so that completion and the next block's first byte fall on adjacent edges.

// File: rtl/ecc_stream_pkg.sv
package ecc_stream_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned COL_W  = 6;

  typedef logic [COL_W-1:0] col_par_t;

  typedef struct packed {
    logic     odd;
    col_par_t col;
  } byte_par_t;
endpackage

// File: rtl/ecc_byte_parity.sv
module ecc_byte_parity
  import ecc_stream_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output byte_par_t         par_o
);
  always_comb begin
    par_o.col[0] = data_i[0] ^ data_i[2] ^ data_i[4] ^ data_i[6];
    par_o.col[1] = data_i[1] ^ data_i[3] ^ data_i[5] ^ data_i[7];
    par_o.col[2] = data_i[0] ^ data_i[1] ^ data_i[4] ^ data_i[5];
    par_o.col[3] = data_i[2] ^ data_i[3] ^ data_i[6] ^ data_i[7];
    par_o.col[4] = ^data_i[3:0];
    par_o.col[5] = ^data_i[7:4];
    par_o.odd    = ^data_i;
  end
endmodule

// File: rtl/ecc_block_counter.sv
module ecc_block_counter #(
  parameter int unsigned BLOCK_BYTES = 256,
  parameter int unsigned IDX_W       = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             valid_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(BLOCK_BYTES - 1);

  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] base;

  // index of the byte on the data port this cycle
  assign base   = start_i ? '0 : idx_q;
  assign idx_o  = base;
  assign last_o = valid_i && (base == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      idx_q <= '0;
    else if (valid_i) idx_q <= last_o ? '0 : base + 1'b1;
    else if (start_i) idx_q <= '0;
  end

  // R2
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_i && !start_i) |=> $stable(idx_q));

  // R7
  start_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && valid_i) |=> (idx_q == IDX_W'(1)));
endmodule

// File: rtl/ecc_parity_accum.sv
module ecc_parity_accum
  import ecc_stream_pkg::*;
#(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic             wrap_i,
  input  logic [IDX_W-1:0] idx_i,
  input  byte_par_t        par_i,
  output col_par_t         col_o,
  output logic [IDX_W-1:0] line_t_o,
  output logic [IDX_W-1:0] line_c_o
);
  col_par_t         col_q;
  logic [IDX_W-1:0] lt_q, lc_q;
  logic             hit;

  // folded values including the byte on the port this cycle
  always_comb begin
    hit      = take_i && par_i.odd;
    col_o    = (clear_i ? '0 : col_q) ^ (take_i ? par_i.col : '0);
    line_t_o = (clear_i ? '0 : lt_q)  ^ (hit ? idx_i : '0);
    line_c_o = (clear_i ? '0 : lc_q)  ^ (hit ? ~idx_i : '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      lt_q  <= '0;
      lc_q  <= '0;
    end else if (wrap_i) begin
      col_q <= '0;
      lt_q  <= '0;
      lc_q  <= '0;
    end else if (take_i || clear_i) begin
      col_q <= col_o;
      lt_q  <= line_t_o;
      lc_q  <= line_c_o;
    end
  end

  // R3
  even_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !par_i.odd && !clear_i && !wrap_i) |=> ($stable(lt_q) && $stable(lc_q)));
endmodule

// File: rtl/ecc_code_pack.sv
module ecc_code_pack
  import ecc_stream_pkg::*;
#(
  parameter int unsigned IDX_W  = 8,
  parameter int unsigned CODE_W = 2*IDX_W + 8
) (
  input  col_par_t          col_i,
  input  logic [IDX_W-1:0]  line_t_i,
  input  logic [IDX_W-1:0]  line_c_i,
  output logic [CODE_W-1:0] code_o
);
  logic [2*IDX_W-1:0] weave;

  for (genvar i = 0; i < IDX_W; i++) begin : g_weave
    assign weave[2*i+1] = line_t_i[i];
    assign weave[2*i]   = line_c_i[i];
  end

  assign code_o = {~weave, ~col_i, 2'b11};
endmodule

// File: rtl/hamming_ecc_stream.sv
module hamming_ecc_stream
  import ecc_stream_pkg::*;
#(
  parameter  int unsigned BLOCK_BYTES = 256,
  localparam int unsigned IDX_W       = $clog2(BLOCK_BYTES),
  localparam int unsigned CODE_W      = 2*IDX_W + 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              done_o,
  output logic [CODE_W-1:0] ecc_o
);
  logic [IDX_W-1:0]  idx;
  logic              last;
  byte_par_t         par;
  col_par_t          col_fold;
  logic [IDX_W-1:0]  lt_fold, lc_fold;
  logic [CODE_W-1:0] code_next;
  logic              done_q;
  logic [CODE_W-1:0] ecc_q;

  ecc_block_counter #(.BLOCK_BYTES(BLOCK_BYTES), .IDX_W(IDX_W)) u_cnt (
    .clk_i, .rst_ni, .start_i, .valid_i, .idx_o(idx), .last_o(last)
  );

  ecc_byte_parity u_par (.data_i, .par_o(par));

  ecc_parity_accum #(.IDX_W(IDX_W)) u_acc (
    .clk_i, .rst_ni, .clear_i(start_i), .take_i(valid_i), .wrap_i(last),
    .idx_i(idx), .par_i(par), .col_o(col_fold), .line_t_o(lt_fold), .line_c_o(lc_fold)
  );

  ecc_code_pack #(.IDX_W(IDX_W), .CODE_W(CODE_W)) u_pack (
    .col_i(col_fold), .line_t_i(lt_fold), .line_c_i(lc_fold), .code_o(code_next)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      ecc_q  <= '0;
    end else begin
      done_q <= last;
      if (last) ecc_q <= code_next;
    end
  end

  assign done_o = done_q;
  assign ecc_o  = ecc_q;

  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R5
  done_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> $past(valid_i));

  // R6
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(ecc_o));

  // R4
  code_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ecc_o[1:0] == 2'b11));

  // R7
  start_no_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> !done_o);
endmodule

// File: tb/hamming_ecc_stream_bench.sv
module hamming_ecc_stream_bench;
  localparam int NB = 256;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start, valid;
  logic [7:0]  data;
  logic        done;
  logic [23:0] ecc;

  always #10 clk = ~clk;

  hamming_ecc_stream u_hamming_ecc_stream (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .valid_i(valid),
    .data_i(data), .done_o(done), .ecc_o(ecc)
  );

  int          vecs = 0, errs = 0;
  bit          finished = 0;
  int          m_idx;
  bit [5:0]    m_col;
  bit [7:0]    m_t, m_c;
  bit          m_done;
  bit [23:0]   m_code;
  int unsigned seed = 32'h1234_5678;

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit [23:0] build(bit [5:0] col, bit [7:0] t, bit [7:0] c);
    bit [15:0] w;
    for (int k = 0; k < 8; k++) begin
      w[15-2*k] = t[7-k];
      w[14-2*k] = c[7-k];
    end
    return {~w, ~col, 2'b11};
  endfunction

  task automatic model_step(bit s, bit v, bit [7:0] d);
    bit odd;
    bit [5:0] cp;
    m_done = 0;
    if (s) begin m_idx = 0; m_col = 0; m_t = 0; m_c = 0; end
    if (v) begin
      odd = 0; cp = 0;
      for (int b = 0; b < 8; b++) begin
        if (d[b]) begin
          odd ^= 1'b1;
          if (b % 2 == 0) cp[0] ^= 1'b1; else cp[1] ^= 1'b1;
          if (b % 4 < 2)  cp[2] ^= 1'b1; else cp[3] ^= 1'b1;
          if (b < 4)      cp[4] ^= 1'b1; else cp[5] ^= 1'b1;
        end
      end
      m_col ^= cp;
      if (odd) begin
        m_t ^= 8'(m_idx);
        m_c ^= ~8'(m_idx);
      end
      if (m_idx == NB - 1) begin
        m_code = build(m_col, m_t, m_c);
        m_done = 1;
        m_idx = 0; m_col = 0; m_t = 0; m_c = 0;
      end else m_idx++;
    end
  endtask

  task automatic step(bit s, bit v, bit [7:0] d);
    start = s; valid = v; data = d;
    @(posedge clk);
    model_step(s, v, d);
    @(negedge clk);
    check("R5 R2 R7 R8 done", {23'd0, done}, {23'd0, m_done});
    if (m_done) begin
      check("R3 line code", {8'd0, ecc[23:8]}, {8'd0, m_code[23:8]});
      check("R4 column code", {16'd0, ecc[7:0]}, {16'd0, m_code[7:0]});
    end else begin
      check("R6 hold", ecc, m_code);
    end
  endtask

  function automatic bit [7:0] rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed[23:16];
  endfunction

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errs++;
      $display("FAIL R2 watchdog act=hung exp=finished");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 0; start = 0; valid = 0; data = 0;
    m_idx = 0; m_col = 0; m_t = 0; m_c = 0; m_done = 0; m_code = 0;
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset done", {23'd0, done}, 24'd0);
    check("R1 reset code", ecc, 24'd0);
    rst_n = 1;
    step(0, 0, 8'h00);

    // R9 erased block, start with first byte
    step(1, 1, 8'hFF);
    for (int i = 1; i < NB; i++) step(0, 1, 8'hFF);
    check("R9 erased code", ecc, 24'hFFFFFF);
    step(0, 0, 8'h00);
    check("R6 hold after erased", ecc, 24'hFFFFFF);

    // R2 counting data with idle gaps, start alone
    step(1, 0, 8'h00);
    for (int i = 0; i < NB; i++) begin
      if (i % 7 == 3) step(0, 0, 8'hA5);
      step(0, 1, 8'(i));
    end

    // R8 back-to-back random blocks, no start
    for (int blk = 0; blk < 2; blk++)
      for (int i = 0; i < NB; i++) step(0, 1, rnd());

    // R7 start in the middle of a block
    for (int i = 0; i < 100; i++) step(0, 1, rnd());
    step(1, 1, rnd());
    for (int i = 1; i < NB; i++) step(0, 1, rnd());

    // R7 start landing on the would-be last byte
    step(1, 1, rnd());
    for (int i = 1; i < NB - 1; i++) step(0, 1, rnd());
    step(1, 1, 8'h5A);
    for (int i = 1; i < NB; i++) step(0, 1, rnd());

    // R3 single odd byte at a known index
    step(1, 0, 8'h00);
    for (int i = 0; i < NB; i++) step(0, 1, (i == 173) ? 8'h08 : 8'h00);
    step(0, 0, 8'h00);
    step(0, 0, 8'h00);

    finished = 1;
    summary();
    $finish;
  end
endmodule